// File: doc/BRIEF.md
# GPIO Pad Register Bank

This block holds the control state for a bank of general-purpose I/O pads and exposes it through a plain 32-bit register bus. Every pad owns a group of four 32-bit words. The group holds a configuration word with a function selector and three interrupt trigger controls, a second configuration word for general use, a value word and a spare word. The value word carries active-low input and output enables next to the level bit. Writing the level bit sets the level the pad drives. Reading it returns the level seen on the pad.

Pad inputs pass through a two-flop synchronizer. The synchronized level feeds both the value word readback and an output for the trigger detection logic. The function selector and the trigger bits leave the block as plain per-pad outputs, for use by the mux routing and the interrupt logic that sit elsewhere. The bus has a single request phase. A write takes effect at the clock edge that samples it. Read data is registered and appears after that edge.

Top module: `gpio_pad_bank`

## Requirements
- R1: `req_addr` is a word address. Bits [1:0] select the word inside a pad group: 0 is the configuration word, 1 the second configuration word, 2 the value word and 3 the spare word. The bits above select the pad. This matches byte address pad*16 plus 0x0, 0x4, 0x8 or 0xC. A write changes only the addressed word of the addressed pad.
- R2: After reset, every word reads zero except the value word, which reads 0x6 (both enables off, level 0). `pad_out`, `pad_oe`, `pad_ie`, `mux_sel` and all trigger outputs are 0.
- R3: Value word bit 1 is the output enable, active low. `pad_oe[n]` equals the inverse of that bit. `pad_out[n]` follows value word bit 0 as written.
- R4: Value word bit 2 is the input enable, active low, and `pad_ie[n]` is its inverse. While bit 2 is 0, read bit 0 returns the synchronized pad input. While bit 2 is 1, read bit 0 returns the stored level.
- R5: `pad_in` is sampled by two flops in series. A change set up before clock edge k appears on `pad_lvl_sync` after edge k+1. It appears in value-word read data captured at edge k+2, and not in read data captured at edge k or k+1.
- R6: Configuration word bits 2:0 drive `mux_sel`. Bit 26 drives `trig_fall`, bit 25 drives `trig_rise` and bit 24 drives `trig_level`. All other bits of this word read as zero.
- R7: The second configuration word and the spare word store all 32 written bits and read them back unchanged.
- R8: Value word bits 31:3 read as zero whatever was written to them.
- R9: `rsp_rdata` loads the addressed word at the clock edge that samples a read request. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | WADDR_W | Word address: pad index above bits [1:0] |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Driven output levels |
| pad_oe | output | NUM_PADS | Output driver enables, active high |
| pad_ie | output | NUM_PADS | Input buffer enables, active high |
| pad_lvl_sync | output | NUM_PADS | Synchronized input levels for trigger detection |
| mux_sel | output | 3*NUM_PADS | Function selector per pad, pad n at bits [3n+2:3n] |
| trig_fall | output | NUM_PADS | Falling-edge trigger control per pad |
| trig_rise | output | NUM_PADS | Rising-edge trigger control per pad |
| trig_level | output | NUM_PADS | Level trigger control per pad |

## Verification
Two functions can land in the same cycle: a bus write to a pad's value word, and a change on that pad's raw input. The bench provokes this by changing `pad_in` at the same moment it issues a write that enables the pad's input and output and sets its level. It then checks that `pad_out` and `pad_oe` take the written values after one edge. Back-to-back reads must show the old input level and then the new one, exactly at the synchronizer latency, unaffected by the level just written.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned MUX_W  = 3;

  // word index inside a pad's register group
  typedef enum logic [1:0] {
    WSEL_CFG   = 2'd0,
    WSEL_CFG2  = 2'd1,
    WSEL_VAL   = 2'd2,
    WSEL_SPARE = 2'd3
  } wsel_e;

  localparam int unsigned CFG_TLVL_BIT  = 24;
  localparam int unsigned CFG_TRISE_BIT = 25;
  localparam int unsigned CFG_TFALL_BIT = 26;
  localparam int unsigned VAL_LVL_BIT   = 0;
  localparam int unsigned VAL_OEN_BIT   = 1;
  localparam int unsigned VAL_IEN_BIT   = 2;

  typedef struct packed {
    logic [MUX_W-1:0] mux;
    logic             trig_fall;
    logic             trig_rise;
    logic             trig_lvl;
    logic             ie_n;
    logic             oe_n;
    logic             lvl;
  } pad_ctl_t;

  localparam pad_ctl_t CTL_RESET = '{mux: '0, trig_fall: 1'b0, trig_rise: 1'b0,
                                     trig_lvl: 1'b0, ie_n: 1'b1, oe_n: 1'b1,
                                     lvl: 1'b0};

  function automatic logic [DATA_W-1:0] pack_cfg(input pad_ctl_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[MUX_W-1:0]    = c.mux;
    r[CFG_TLVL_BIT]  = c.trig_lvl;
    r[CFG_TRISE_BIT] = c.trig_rise;
    r[CFG_TFALL_BIT] = c.trig_fall;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_val(input pad_ctl_t c, input logic in_lvl);
    logic [DATA_W-1:0] r;
    r = '0;
    r[VAL_IEN_BIT] = c.ie_n;
    r[VAL_OEN_BIT] = c.oe_n;
    r[VAL_LVL_BIT] = c.ie_n ? c.lvl : in_lvl;
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pad_slot.sv
module gpio_pad_slot
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wsel_e             wsel,
  input  logic [DATA_W-1:0] wdata,
  output pad_ctl_t          ctl,
  output logic [DATA_W-1:0] cfg2,
  output logic [DATA_W-1:0] spare
);

  pad_ctl_t          ctl_d;
  logic              ctl_en;
  logic              cfg2_en;
  logic              spare_en;

  // next-state
  always_comb begin
    ctl_d    = ctl;
    ctl_en   = 1'b0;
    cfg2_en  = 1'b0;
    spare_en = 1'b0;
    if (wr_en) begin
      unique case (wsel)
        WSEL_CFG: begin
          ctl_en          = 1'b1;
          ctl_d.mux       = wdata[MUX_W-1:0];
          ctl_d.trig_lvl  = wdata[CFG_TLVL_BIT];
          ctl_d.trig_rise = wdata[CFG_TRISE_BIT];
          ctl_d.trig_fall = wdata[CFG_TFALL_BIT];
        end
        WSEL_VAL: begin
          ctl_en     = 1'b1;
          ctl_d.ie_n = wdata[VAL_IEN_BIT];
          ctl_d.oe_n = wdata[VAL_OEN_BIT];
          ctl_d.lvl  = wdata[VAL_LVL_BIT];
        end
        WSEL_CFG2:  cfg2_en  = 1'b1;
        WSEL_SPARE: spare_en = 1'b1;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= CTL_RESET;
      cfg2  <= '0;
      spare <= '0;
    end else begin
      if (ctl_en)   ctl   <= ctl_d;
      if (cfg2_en)  cfg2  <= wdata;
      if (spare_en) spare <= wdata;
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic     [IDX_W-1:0]               idx,
  input  wsel_e                              wsel,
  input  pad_ctl_t [NUM_PADS-1:0]            ctl_all,
  input  logic     [NUM_PADS-1:0][DATA_W-1:0] cfg2_all,
  input  logic     [NUM_PADS-1:0][DATA_W-1:0] spare_all,
  input  logic     [NUM_PADS-1:0]            in_sync,
  output logic     [DATA_W-1:0]              rdata
);

  always_comb begin
    rdata = '0;
    if (int'(idx) < NUM_PADS) begin
      unique case (wsel)
        WSEL_CFG:   rdata = pack_cfg(ctl_all[idx]);
        WSEL_CFG2:  rdata = cfg2_all[idx];
        WSEL_VAL:   rdata = pack_val(ctl_all[idx], in_sync[idx]);
        WSEL_SPARE: rdata = spare_all[idx];
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned WADDR_W  = $clog2(NUM_PADS) + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [WADDR_W-1:0]        req_addr,
  input  logic [31:0]               req_wdata,
  output logic [31:0]               rsp_rdata,
  input  logic [NUM_PADS-1:0]       pad_in,
  output logic [NUM_PADS-1:0]       pad_out,
  output logic [NUM_PADS-1:0]       pad_oe,
  output logic [NUM_PADS-1:0]       pad_ie,
  output logic [NUM_PADS-1:0]       pad_lvl_sync,
  output logic [3*NUM_PADS-1:0]     mux_sel,
  output logic [NUM_PADS-1:0]       trig_fall,
  output logic [NUM_PADS-1:0]       trig_rise,
  output logic [NUM_PADS-1:0]       trig_level
);

  localparam int unsigned IDX_W = WADDR_W - 2;

  wsel_e                               wsel;
  logic     [IDX_W-1:0]                pad_idx;
  logic                                rd_req;
  logic                                wr_req;
  pad_ctl_t [NUM_PADS-1:0]             ctl_all;
  logic     [NUM_PADS-1:0][DATA_W-1:0] cfg2_all;
  logic     [NUM_PADS-1:0][DATA_W-1:0] spare_all;
  logic     [DATA_W-1:0]               rd_word;
  logic     [DATA_W-1:0]               rsp_d;

  assign wsel    = wsel_e'(req_addr[1:0]);
  assign pad_idx = req_addr[WADDR_W-1:2];
  assign rd_req  = req_valid & ~req_write;
  assign wr_req  = req_valid &  req_write;

  gpio_in_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (pad_lvl_sync)
  );

  for (genvar gi = 0; gi < NUM_PADS; gi++) begin : g_pad
    pad_ctl_t          slot_ctl;
    logic [DATA_W-1:0] slot_cfg2;
    logic [DATA_W-1:0] slot_spare;
    logic              slot_wr;

    assign slot_wr = wr_req && (pad_idx == IDX_W'(gi));

    gpio_pad_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (slot_wr),
      .wsel  (wsel),
      .wdata (req_wdata),
      .ctl   (slot_ctl),
      .cfg2  (slot_cfg2),
      .spare (slot_spare)
    );

    assign ctl_all[gi]   = slot_ctl;
    assign cfg2_all[gi]  = slot_cfg2;
    assign spare_all[gi] = slot_spare;

    assign pad_out[gi]              = slot_ctl.lvl;
    assign pad_oe[gi]               = ~slot_ctl.oe_n;
    assign pad_ie[gi]               = ~slot_ctl.ie_n;
    assign mux_sel[gi*MUX_W +: MUX_W] = slot_ctl.mux;
    assign trig_fall[gi]            = slot_ctl.trig_fall;
    assign trig_rise[gi]            = slot_ctl.trig_rise;
    assign trig_level[gi]           = slot_ctl.trig_lvl;
  end

  gpio_read_mux #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W)) u_rmux (
    .idx       (pad_idx),
    .wsel      (wsel),
    .ctl_all   (ctl_all),
    .cfg2_all  (cfg2_all),
    .spare_all (spare_all),
    .in_sync   (pad_lvl_sync),
    .rdata     (rd_word)
  );

  // read response: next-state and register
  always_comb begin
    rsp_d = rsp_rdata;
    if (rd_req) rsp_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_rdata <= '0;
    else        rsp_rdata <= rsp_d;
  end

endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned WADDR_W  = $clog2(NUM_PADS) + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [WADDR_W-1:0]  req_addr,
  input logic                wr_oe_bit,
  input logic [31:0]         rsp_rdata,
  input logic [NUM_PADS-1:0] pad_in,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] pad_lvl_sync
);

  localparam int unsigned IDX_W = WADDR_W - 2;

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc <= 2'd0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  AST_RESET_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (pad_oe == '0)); // R2

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (pad_lvl_sync == $past(pad_in, 2))); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && !$past(req_valid && !req_write)) |-> $stable(rsp_rdata)); // R9

  AST_VAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[1:0] == 2'd2) |=> (rsp_rdata[31:3] == '0)); // R8

  AST_CFG_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[1:0] == 2'd0)
      |=> (rsp_rdata[31:27] == '0 && rsp_rdata[23:3] == '0)); // R6

  for (genvar gk = 0; gk < NUM_PADS; gk++) begin : g_oe
    AST_OE_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr[1:0] == 2'd2 &&
       req_addr[WADDR_W-1:2] == IDX_W'(gk))
        |=> (pad_oe[gk] == !$past(wr_oe_bit))); // R3
  end

endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(.NUM_PADS(NUM_PADS), .WADDR_W(WADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .wr_oe_bit    (req_wdata[1]),
  .rsp_rdata    (rsp_rdata),
  .pad_in       (pad_in),
  .pad_oe       (pad_oe),
  .pad_lvl_sync (pad_lvl_sync)
);

// File: tb/gpio_pad_bank_tb.sv
module gpio_pad_bank_tb;

  localparam int NP = 8;
  localparam int AW = 5;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_write;
  logic [AW-1:0]   req_addr;
  logic [31:0]     req_wdata;
  logic [31:0]     rsp_rdata;
  logic [NP-1:0]   pad_in;
  logic [NP-1:0]   pad_out;
  logic [NP-1:0]   pad_oe;
  logic [NP-1:0]   pad_ie;
  logic [NP-1:0]   pad_lvl_sync;
  logic [3*NP-1:0] mux_sel;
  logic [NP-1:0]   trig_fall;
  logic [NP-1:0]   trig_rise;
  logic [NP-1:0]   trig_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_cfg  [NP];
  logic [31:0] m_cfg2 [NP];
  logic [31:0] m_val  [NP];
  logic [31:0] m_spare[NP];

  gpio_pad_bank #(.NUM_PADS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_lvl_sync(pad_lvl_sync), .mux_sel(mux_sel), .trig_fall(trig_fall),
    .trig_rise(trig_rise), .trig_level(trig_level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_cfg[p] = '0; m_cfg2[p] = '0; m_val[p] = 32'h6; m_spare[p] = '0;
    end
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
    case (a[1:0])
      2'd0: m_cfg[a[4:2]]   = d & 32'h0700_0007;
      2'd1: m_cfg2[a[4:2]]  = d;
      2'd2: m_val[a[4:2]]   = d & 32'h7;
      default: m_spare[a[4:2]] = d;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    int p = int'(a[4:2]);
    logic [31:0] v;
    case (a[1:0])
      2'd0: return m_cfg[p];
      2'd1: return m_cfg2[p];
      2'd2: begin
        v = m_val[p];
        if (!v[2]) v[0] = pad_in[p];
        return v;
      end
      default: return m_spare[p];
    endcase
  endfunction

  // tasks are entered at a falling edge and return at the next one
  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a);
    logic [31:0] got;
    logic [31:0] exp;
    exp = exp_rd(a);
    bus_rd(a, got);
    check_eq(req, got, exp);
  endtask

  task automatic check_ports(input string req);
    for (int p = 0; p < NP; p++) begin
      logic [8:0] act;
      logic [8:0] exp;
      act = {pad_ie[p], pad_oe[p], pad_out[p], trig_fall[p], trig_rise[p],
             trig_level[p], mux_sel[3*p +: 3]};
      exp = {~m_val[p][2], ~m_val[p][1], m_val[p][0], m_cfg[p][26],
             m_cfg[p][25], m_cfg[p][24], m_cfg[p][2:0]};
      check_eq(req, {23'd0, act}, {23'd0, exp});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] hold;
    int seed_init;
    seed_init = $urandom(32'd20240611);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; pad_in = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state at ports and in every word
    check_eq("R2 pad_oe after reset", {24'd0, pad_oe}, 32'd0);
    check_eq("R2 pad_ie after reset", {24'd0, pad_ie}, 32'd0);
    check_ports("R2 ports after reset");
    for (int a = 0; a < 4 * NP; a++) rd_check("R2 reset read", AW'(a));

    // R7: full-width storage
    bus_wr({3'd5, 2'd1}, 32'hDEAD_BEEF);
    bus_wr({3'd7, 2'd3}, 32'h1234_5678);
    rd_check("R7 cfg2 readback", {3'd5, 2'd1});
    rd_check("R7 spare readback", {3'd7, 2'd3});

    // R6: configuration fields and outputs
    bus_wr({3'd2, 2'd0}, 32'hFFFF_FFFF);
    check_ports("R6 cfg all ones");
    rd_check("R6 cfg masked read", {3'd2, 2'd0});
    bus_wr({3'd2, 2'd0}, 32'h0200_0005);
    check_ports("R6 cfg rise only");
    rd_check("R6 cfg rise read", {3'd2, 2'd0});

    // R1 / R3: value word of pad 4, neighbours untouched
    bus_wr({3'd4, 2'd2}, 32'hFFFF_FFF9);
    check_eq("R3 pad_out[4]", {31'd0, pad_out[4]}, 32'd1);
    check_eq("R3 pad_oe[4]", {31'd0, pad_oe[4]}, 32'd1);
    rd_check("R8 value upper bits zero", {3'd4, 2'd2});
    rd_check("R1 neighbour value word", {3'd5, 2'd2});
    rd_check("R1 neighbour cfg2 word", {3'd4, 2'd1});

    // R4: level source depends on input enable
    bus_wr({3'd6, 2'd2}, 32'h5);
    rd_check("R4 input off reads stored level", {3'd6, 2'd2});
    bus_wr({3'd6, 2'd2}, 32'h1);
    check_eq("R4 pad_ie[6]", {31'd0, pad_ie[6]}, 32'd1);
    rd_check("R4 input on reads pad", {3'd6, 2'd2});

    // R5: synchronizer latency on pad 6
    pad_in[6] = 1'b1;
    bus_rd({3'd6, 2'd2}, rd);
    check_eq("R5 read at edge k", rd, 32'h0);
    check_eq("R5 sync after edge k", {31'd0, pad_lvl_sync[6]}, 32'd0);
    bus_rd({3'd6, 2'd2}, rd);
    check_eq("R5 read at edge k+1", rd, 32'h0);
    check_eq("R5 sync after edge k+1", {31'd0, pad_lvl_sync[6]}, 32'd1);
    bus_rd({3'd6, 2'd2}, rd);
    check_eq("R5 read at edge k+2", rd, 32'h1);

    // R9: read data holds through a write and idle cycles
    hold = rsp_rdata;
    bus_wr({3'd0, 2'd3}, 32'hA5A5_0000);
    @(negedge clk);
    check_eq("R9 rdata holds", rsp_rdata, hold);

    // R3 with R5: value write and input change in the same cycle
    pad_in[3] = 1'b1;
    bus_wr({3'd3, 2'd2}, 32'h1);
    check_eq("R3 same-cycle pad_out[3]", {31'd0, pad_out[3]}, 32'd1);
    check_eq("R3 same-cycle pad_oe[3]", {31'd0, pad_oe[3]}, 32'd1);
    bus_rd({3'd3, 2'd2}, rd);
    check_eq("R5 same-cycle old level", rd, 32'h0);
    bus_rd({3'd3, 2'd2}, rd);
    check_eq("R5 same-cycle new level", rd, 32'h1);

    // random mix
    for (int it = 0; it < 800; it++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 8);
      a  = AW'($urandom);
      if (op < 3) bus_wr(a, $urandom);
      else if (op < 6) rd_check("R1 random read", a);
      else if (op == 6) begin
        pad_in = NP'($urandom);
        repeat (3) @(negedge clk);
      end else check_ports("R3 R4 R6 random ports");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule